// File: doc/BRIEF.md
# Configuration Completion Receiver

This block waits for the answer to a single configuration request. After the requester pulses `req_start` with the access size and the low address bits, the block watches a stream of 64-bit completion beats. Each beat carries its own start and end markers. The start beat gives the completion status in its upper half. The end beat gives the read dword in its lower half. Beats between the two are accepted and then discarded.

When the end beat arrives, the block drops `busy` and raises `done` for one cycle. With it goes either a success flag and the read result, or an error with all-ones data. For byte and halfword reads, the result is the addressed lane of the returned dword, moved down to bit 0.

A bounded poll wait guards the request. The wait has `POLL_LIMIT` poll intervals of `POLL_CYC` clock cycles each. If no end beat arrives in that window, the block reports the device as not found.

Top module: `cfgcpl_receiver`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `ok` are all 0.
- R2: A `req_start` pulse while idle makes `busy` read 1 in the following cycle. Beats that arrive while idle produce no `done`.
- R3: A valid beat with `beat_sop` set captures the completion status from `beat_data[47:45]`, which is bits 15:13 of the upper half. A beat with both markers uses its own status.
- R4: On a valid `beat_eop` beat with zero status, the next cycle shows `done`=1 and `ok`=1. In that same cycle, for a dword access (`req_size` 2 or 3), `rd_data` equals `beat_data[31:0]`.
- R5: On a valid `beat_eop` beat with nonzero status, the next cycle shows `done`=1, `ok`=0 and `rd_data`=32'hFFFF_FFFF.
- R6: Valid beats with neither marker set change neither the status nor the data. A middle beat whose bits 47:45 are nonzero does not turn a success into a failure.
- R7: The status is preset to a nonzero value on each request. An end beat with no start beat before it therefore reports failure (`ok`=0, all-ones data).
- R8: With no end beat, `done` rises with `ok`=0 exactly POLL_CYC*POLL_LIMIT cycles after the cycle in which the request was taken (2000 cycles with the defaults). It never rises earlier.
- R9: For `req_size`=0 (byte), `rd_data` = (dword >> 8*`req_addr`) & 8'hFF.
- R10: For `req_size`=1 (halfword), `rd_data` = (dword >> 16*`req_addr[1]`) & 16'hFFFF.
- R11: `done` lasts exactly one cycle, and `busy` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request issued; begin waiting (taken only when idle) |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 dword |
| req_addr | input | 2 | Low byte address of the access |
| beat_valid | input | 1 | Completion beat present |
| beat_sop | input | 1 | Beat is first of a completion |
| beat_eop | input | 1 | Beat is last of a completion |
| beat_data | input | 64 | Beat payload |
| busy | output | 1 | Waiting for a completion |
| done | output | 1 | One-cycle result strobe |
| ok | output | 1 | Result is a successful read |
| rd_data | output | 32 | Extracted read data, all ones on failure |

## Verification
The assertions assume that `req_start` is pulsed only while `busy` is 0. They also assume that beats matter only while a request is outstanding, and that `req_size` and `req_addr` are held steady for the whole request. Every scenario in the bench begins a request only after the previous `done` has been seen. The bench changes size and address only together with the start pulse, and it drives beats on the falling edge one at a time, so the stimulus stays inside these assumptions.

// File: rtl/cfgcpl_pkg.sv
package cfgcpl_pkg;
  localparam int unsigned STAT_W = 3;
  localparam logic [STAT_W-1:0] STAT_PRESET = 3'b111;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/cfgcpl_poll_timer.sv
module cfgcpl_poll_timer #(
  parameter int unsigned POLL_CYC   = 4,
  parameter int unsigned POLL_LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int unsigned TW = $clog2(POLL_CYC + 1);
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] TLAST = TW'(POLL_CYC - 1);
  localparam logic [PW-1:0] PLAST = PW'(POLL_LIMIT - 1);

  logic [TW-1:0] tick_q;
  logic [PW-1:0] poll_q;
  logic          tick_wrap;

  assign tick_wrap = (tick_q == TLAST);
  assign expire    = run && tick_wrap && (poll_q == PLAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      tick_q <= '0;
      poll_q <= '0;
    end else if (run) begin
      if (tick_wrap) begin
        tick_q <= '0;
        poll_q <= poll_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgcpl_lane_pick.sv
module cfgcpl_lane_pick
  import cfgcpl_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic [HALF_W-1:0] dword,
  input  logic [1:0]        size,
  input  logic [1:0]        addr,
  output logic [HALF_W-1:0] lane
);
  logic [HALF_W-1:0] byte_sh;
  logic [HALF_W-1:0] half_sh;

  assign byte_sh = dword >> (8 * addr);
  assign half_sh = dword >> (16 * addr[1]);

  always_comb begin
    if (size == SZ_BYTE)      lane = {{(HALF_W-8){1'b0}},  byte_sh[7:0]};
    else if (size == SZ_HALF) lane = {{(HALF_W-16){1'b0}}, half_sh[15:0]};
    else                      lane = dword;
  end
endmodule

// File: rtl/cfgcpl_receiver.sv
module cfgcpl_receiver
  import cfgcpl_pkg::*;
#(
  parameter int unsigned HALF_W     = 32,
  parameter int unsigned POLL_CYC   = 4,
  parameter int unsigned POLL_LIMIT = 500,
  parameter int unsigned STAT_LSB   = 13
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_start,
  input  logic [1:0]            req_size,
  input  logic [1:0]            req_addr,
  input  logic                  beat_valid,
  input  logic                  beat_sop,
  input  logic                  beat_eop,
  input  logic [2*HALF_W-1:0]   beat_data,
  output logic                  busy,
  output logic                  done,
  output logic                  ok,
  output logic [HALF_W-1:0]     rd_data
);
  localparam int unsigned ST_HI = HALF_W + STAT_LSB + STAT_W - 1;
  localparam int unsigned ST_LO = HALF_W + STAT_LSB;

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_now;
  logic [1:0]        size_q;
  logic [1:0]        addr_q;
  logic              take_req;
  logic              end_beat;
  logic              expire;
  logic [HALF_W-1:0] lane;

  assign take_req = req_start && !busy;
  assign end_beat = busy && beat_valid && beat_eop;
  assign stat_now = (beat_valid && beat_sop) ? beat_data[ST_HI:ST_LO] : stat_q;

  cfgcpl_poll_timer #(
    .POLL_CYC  (POLL_CYC),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (take_req),
    .run   (busy),
    .expire(expire)
  );

  cfgcpl_lane_pick #(.HALF_W(HALF_W)) u_lane (
    .dword(beat_data[HALF_W-1:0]),
    .size (size_q),
    .addr (addr_q),
    .lane (lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ok      <= 1'b0;
      rd_data <= '1;
      stat_q  <= STAT_PRESET;
      size_q  <= '0;
      addr_q  <= '0;
    end else begin
      done <= 1'b0;
      if (take_req) begin
        busy   <= 1'b1;
        stat_q <= STAT_PRESET;
        size_q <= req_size;
        addr_q <= req_addr;
      end else if (busy) begin
        if (beat_valid && beat_sop) stat_q <= stat_now;
        if (end_beat) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (stat_now == '0) begin
            ok      <= 1'b1;
            rd_data <= lane;
          end else begin
            ok      <= 1'b0;
            rd_data <= '1;
          end
        end else if (expire) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          ok      <= 1'b0;
          rd_data <= '1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgcpl_receiver_chk.sv
module cfgcpl_receiver_chk #(
  parameter int unsigned HALF_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_start,
  input logic              beat_valid,
  input logic              beat_eop,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic [HALF_W-1:0] rd_data
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst) (req_start && !busy) |=> busy);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !busy |=> !done);
  // R4
  end_done_chk: assert property (@(posedge clk) disable iff (rst) (busy && beat_valid && beat_eop) |=> done);
  // R5
  fail_ones_chk: assert property (@(posedge clk) disable iff (rst) (done && !ok) |-> (rd_data == '1));
endmodule

bind cfgcpl_receiver cfgcpl_receiver_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_start (req_start),
  .beat_valid(beat_valid),
  .beat_eop  (beat_eop),
  .busy      (busy),
  .done      (done),
  .ok        (ok),
  .rd_data   (rd_data)
);

// File: tb/cfgcpl_receiver_tb.sv
`timescale 1ns/1ps
module cfgcpl_receiver_tb;
  localparam int unsigned POLL_CYC   = 4;
  localparam int unsigned POLL_LIMIT = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic [1:0]  req_size = 2'd2;
  logic [1:0]  req_addr = 2'd0;
  logic        beat_valid = 1'b0;
  logic        beat_sop = 1'b0;
  logic        beat_eop = 1'b0;
  logic [63:0] beat_data = '0;
  logic        busy, done, ok;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cfgcpl_receiver #(.POLL_CYC(POLL_CYC), .POLL_LIMIT(POLL_LIMIT)) u_dut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_size(req_size),
    .req_addr(req_addr), .beat_valid(beat_valid), .beat_sop(beat_sop),
    .beat_eop(beat_eop), .beat_data(beat_data), .busy(busy), .done(done),
    .ok(ok), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] st, input logic [31:0] lo);
    return {16'h0, st, 13'h0, lo};
  endfunction

  task automatic request(input logic [1:0] sz, input logic [1:0] ad);
    @(negedge clk);
    req_start = 1'b1; req_size = sz; req_addr = ad;
    @(posedge clk);
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic beat(input logic s, input logic e, input logic [63:0] d);
    beat_valid = 1'b1; beat_sop = s; beat_eop = e; beat_data = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    beat_valid = 1'b0; beat_sop = 1'b0; beat_eop = 1'b0;
  endtask

  // Result appears after the end-beat edge; sampled at the following negedge.
  task automatic expect_result(input string req, input logic exp_ok, input logic [31:0] exp_d);
    check({req, " done"}, {31'd0, done}, 32'd1);
    check({req, " ok"}, {31'd0, ok}, {31'd0, exp_ok});
    check({req, " data"}, rd_data, exp_d);
  endtask

  task automatic t_reset;
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 ok", {31'd0, ok}, 32'd0);
  endtask

  task automatic t_idle_beat;
    @(negedge clk);
    beat(1'b1, 1'b1, mk(3'd0, 32'h1234_5678));
    check("R2 idle beat no done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_dword_ok;
    request(2'd2, 2'd0);
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    beat(1'b1, 1'b0, mk(3'd0, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'hCAFE_F00D));
    expect_result("R4 R3 dword", 1'b1, 32'hCAFE_F00D);
    check("R11 busy low with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_bad_status;
    request(2'd3, 2'd0);
    beat(1'b1, 1'b0, mk(3'b100, 32'h0));
    beat(1'b0, 1'b1, mk(3'd0, 32'h1111_2222));
    expect_result("R5 R3 bad status", 1'b0, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic t_middle;
    request(2'd2, 2'd0);
    beat(1'b1, 1'b0, mk(3'd0, 32'h0));
    beat(1'b0, 1'b0, mk(3'b111, 32'hDEAD_DEAD));
    beat(1'b0, 1'b0, mk(3'b010, 32'hBEEF_BEEF));
    beat(1'b0, 1'b1, mk(3'd0, 32'h0BAD_F00D));
    expect_result("R6 middle beats", 1'b1, 32'h0BAD_F00D);
    @(negedge clk);
  endtask

  task automatic t_no_sop;
    request(2'd2, 2'd0);
    beat(1'b0, 1'b1, mk(3'd0, 32'h5555_AAAA));
    expect_result("R7 end without start", 1'b0, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic t_byte;
    logic [31:0] dw;
    dw = 32'h4433_2211;
    for (int a = 0; a < 4; a++) begin
      request(2'd0, a[1:0]);
      beat(1'b1, 1'b1, mk(3'd0, dw));
      expect_result("R9 byte lane", 1'b1, (dw >> (8 * a)) & 32'hFF);
      @(negedge clk);
    end
  endtask

  task automatic t_half;
    logic [31:0] dw;
    dw = 32'h4433_2211;
    for (int a = 0; a < 4; a++) begin
      request(2'd1, a[1:0]);
      beat(1'b1, 1'b1, mk(3'd0, dw));
      expect_result("R10 half lane", 1'b1, (a >= 2) ? 32'h4433 : 32'h2211);
      @(negedge clk);
    end
  endtask

  task automatic t_timeout;
    int n;
    int first;
    first = -1;
    @(negedge clk);
    req_start = 1'b1; req_size = 2'd2; req_addr = 2'd0;
    @(posedge clk);
    #1;
    req_start = 1'b0;
    for (n = 1; n <= POLL_CYC * POLL_LIMIT + 5; n++) begin
      @(posedge clk);
      #1;
      if (done && first < 0) begin
        first = n;
        check("R8 timeout ok", {31'd0, ok}, 32'd0);
        check("R8 timeout data", rd_data, 32'hFFFF_FFFF);
      end
    end
    check("R8 timeout cycle", first, POLL_CYC * POLL_LIMIT);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle_beat();
    t_dword_ok();
    t_bad_status();
    t_middle();
    t_no_sop();
    t_byte();
    t_half();
    t_timeout();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule